// File: doc/BRIEF.md
# Hash Engine Register Front-End

This block is the bus-facing shell of a two-algorithm block hash engine (SHA-1 and MD5). Software programs a per-transfer control word, fills a sixteen-word data window, and the front-end hands each 64-byte block to a separate compression core, together with the chaining digest, the running byte total and the per-block flags. The compression rounds and the padding live in that core. The front-end only keeps the context, sequences the blocks and signals completion.

The chaining context is a set of plain read/write registers: five digest words and a processed-byte counter. Software can therefore suspend one message, run another and later resume the first by writing its digest and count back, and then issue the next block without the load-initial-constants flag. Completion sets a sticky output-ready flag. That flag can raise a level interrupt. A DMA request can instead pace the window writes one block at a time. A soft-reset bit clears all state and reports through a status bit once the clearing period has passed.

Top module: `hash_reg_front`

## Requirements
- R1: After reset, the control, count, mask and all digest registers read zero. The system-status register reads 1 in bit 0. `irq`, `dma_req` and `core_start` are low.
- R2: Register offsets are as follows. Digest word i is at 4*i (i = 0..4). The count is at 0x14 and the control word at 0x18. The data window is at 0x1C + 4*j (j = 0..15). The revision register is at 0x5C, the mask at 0x60 and the system status at 0x64. The revision register returns the major number in bits 7:4 and the minor number in bits 3:0. The data window and every unmapped offset read zero.
- R3: Control bit 1 (input-ready) reads 1 only when no block is in flight and the remaining length is nonzero. Data-window writes made while it is 0 are dropped. Unused window words are presented to the core as zero.
- R4: The control word holds the following fields. Bit 0 is output-ready, bit 1 is input-ready, bit 2 selects the algorithm (1 = SHA-1, 0 = MD5), bit 3 loads the initial constants, bit 4 closes the hash, and bits 31:5 give the transfer length in bytes. Each block carries min(remaining, 64) bytes, which appear on `core_len`. `core_start` pulses for exactly one cycle, in the cycle after the write to window word ceil(bytes/4)-1, and not earlier.
- R5: `core_init` is high only for the first block after a control write with bit 3 set. `core_close` is high only when bit 4 is set and the block is the last one of the transfer (remaining length of 64 or less).
- R6: The count register is writable by software. It grows by the block's byte count when the core finishes. `core_total` equals the count plus the current block's bytes.
- R7: The digest registers are writable by software and feed `core_ctx`. They are loaded from `core_result` when the core finishes. While MD5 is selected, digest word 4 reads zero.
- R8: Output-ready sets when the core finishes and clears only when 1 is written to control bit 0. Writing 0 there leaves it set. `irq` equals output-ready AND mask bit 2.
- R9: `dma_req` is high while input-ready is high and mask bit 3 is set. It drops after the write that completes the block.
- R10: A control write with a zero length field ends the transfer: input-ready and `dma_req` go low.
- R11: Writing 1 to mask bit 1 clears all registers, including the mask. For RST_CYCLES cycles after that write, system-status bit 0 reads 0, mask bit 1 reads 1, bus writes are ignored and no block starts.
- R12: A transfer longer than 64 bytes is split into successive blocks of 64 bytes followed by the remainder. Input-ready returns after each block until the length is used up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 8 | Byte offset for both read and write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Level interrupt: output-ready and enabled |
| dma_req | output | 1 | Request for the next block's window words |
| core_start | output | 1 | One-cycle pulse launching a block |
| core_algo | output | 1 | 1 = SHA-1, 0 = MD5 |
| core_init | output | 1 | Use the initial constants instead of `core_ctx` |
| core_close | output | 1 | Last block: apply padding |
| core_len | output | 7 | Bytes in this block, 1..64 |
| core_total | output | 32 | Bytes processed including this block |
| core_block | output | 512 | Window word j at bits 32*j+31:32*j |
| core_ctx | output | 160 | Digest word i at bits 32*i+31:32*i |
| core_done | input | 1 | Core finished the block in flight |
| core_result | input | 160 | New digest, same layout as `core_ctx` |

## Verification
A wrong block-size or last-word decode shows up directly. `core_start` either fires one window write too early, or it never fires and input-ready stays high. The sweep over every block length from 1 to 64 exposes this within the block where the fault occurs. Stale context or count state stays hidden until the block completes. It then appears in `core_total`, or in the digest and count read back a few cycles later. The result that the bench's stand-in core returns mixes every context word, block word, flag and total, so any of them being wrong changes the digest. Errors in the flag sequencing appear on `core_init`/`core_close` in the first or last block of a 130-byte transfer. Soft-reset faults appear in the status and mask reads within RST_CYCLES cycles.

// File: rtl/hash_reg_front.sv
module hash_reg_front #(
  parameter int ADDR_W     = 8,
  parameter int REV_MAJOR  = 2,
  parameter int REV_MINOR  = 1,
  parameter int RST_CYCLES = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_we,
  input  logic [7:0]    bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  output logic          irq,
  output logic          dma_req,
  output logic          core_start,
  output logic          core_algo,
  output logic          core_init,
  output logic          core_close,
  output logic [6:0]    core_len,
  output logic [31:0]   core_total,
  output logic [511:0]  core_block,
  output logic [159:0]  core_ctx,
  input  logic          core_done,
  input  logic [159:0]  core_result
);
  localparam int NDIG  = 5;
  localparam int NWIN  = 16;
  localparam int LEN_W = 27;
  localparam int RC_W  = $clog2(RST_CYCLES + 1);
  localparam logic [7:0] A_CNT  = 8'h14;
  localparam logic [7:0] A_CTRL = 8'h18;
  localparam logic [7:0] A_WIN  = 8'h1C;
  localparam logic [7:0] A_WEND = 8'h58;
  localparam logic [7:0] A_REV  = 8'h5C;
  localparam logic [7:0] A_MASK = 8'h60;
  localparam logic [7:0] A_SYS  = 8'h64;

  logic [31:0]      dig [NDIG];
  logic [31:0]      win [NWIN];
  logic [31:0]      cnt;
  logic [LEN_W-1:0] len_q, rem;
  logic             algo_q, init_q, close_q, init_pend;
  logic             out_rdy, busy, start_q;
  logic             aidle_q, ien_q, den_q;
  logic [RC_W-1:0]  rst_cnt;

  wire resetting = rst_cnt != '0;
  wire wr        = bus_we && !resetting;
  wire srst_go   = bus_we && !resetting && bus_addr == A_MASK && bus_wdata[1];
  wire clr       = srst_go || resetting;

  wire       dig_hit = bus_addr <= 8'h10 && bus_addr[1:0] == 2'b00;
  wire [2:0] dig_idx = bus_addr[4:2];
  wire       win_hit = bus_addr >= A_WIN && bus_addr <= A_WEND && bus_addr[1:0] == 2'b00;
  wire [7:0] win_off = bus_addr - A_WIN;
  wire [3:0] win_idx = win_off[5:2];

  wire [6:0] blk = (rem >= LEN_W'(64)) ? 7'd64 : rem[6:0];
  logic [4:0] nwords;
  assign nwords = 5'((8'(blk) + 8'd3) >> 2);
  wire [3:0] last_idx = 4'(nwords - 5'd1);

  wire in_rdy = !busy && rem != '0 && !resetting;
  wire win_go = wr && win_hit && in_rdy && win_idx == last_idx;
  wire fin    = busy && core_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rst_cnt <= '0;
    else if (srst_go)
      rst_cnt <= RC_W'(RST_CYCLES);
    else if (resetting)
      rst_cnt <= rst_cnt - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      for (int i = 0; i < NDIG; i++) dig[i] <= '0;
      for (int j = 0; j < NWIN; j++) win[j] <= '0;
      cnt <= '0; len_q <= '0; rem <= '0;
      algo_q <= 1'b0; init_q <= 1'b0; close_q <= 1'b0; init_pend <= 1'b0;
      out_rdy <= 1'b0; busy <= 1'b0; start_q <= 1'b0;
      aidle_q <= 1'b0; ien_q <= 1'b0; den_q <= 1'b0;
    end else begin
      start_q <= 1'b0;
      if (wr && dig_hit) dig[dig_idx] <= bus_wdata;
      if (wr && bus_addr == A_CNT) cnt <= bus_wdata;
      if (wr && bus_addr == A_CTRL) begin
        len_q     <= bus_wdata[31:5];
        rem       <= bus_wdata[31:5];
        close_q   <= bus_wdata[4];
        init_q    <= bus_wdata[3];
        init_pend <= bus_wdata[3];
        algo_q    <= bus_wdata[2];
        if (bus_wdata[0]) out_rdy <= 1'b0;
        for (int j = 0; j < NWIN; j++) win[j] <= '0;
      end
      if (wr && bus_addr == A_MASK) begin
        den_q   <= bus_wdata[3];
        ien_q   <= bus_wdata[2];
        aidle_q <= bus_wdata[0];
      end
      if (wr && win_hit && in_rdy) win[win_idx] <= bus_wdata;
      if (win_go) begin
        busy    <= 1'b1;
        start_q <= 1'b1;
      end
      if (fin) begin
        for (int i = 0; i < NDIG; i++) dig[i] <= core_result[32*i +: 32];
        for (int j = 0; j < NWIN; j++) win[j] <= '0;
        cnt       <= cnt + 32'(blk);
        rem       <= rem - LEN_W'(blk);
        init_pend <= 1'b0;
        out_rdy   <= 1'b1;
        busy      <= 1'b0;
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (dig_hit)
      bus_rdata = (dig_idx == 3'd4 && !algo_q) ? 32'd0 : dig[dig_idx];
    else
      case (bus_addr)
        A_CNT:   bus_rdata = cnt;
        A_CTRL:  bus_rdata = {len_q, close_q, init_q, algo_q, in_rdy, out_rdy};
        A_REV:   bus_rdata = {24'd0, 4'(REV_MAJOR), 4'(REV_MINOR)};
        A_MASK:  bus_rdata = {28'd0, den_q, ien_q, resetting, aidle_q};
        A_SYS:   bus_rdata = {31'd0, !resetting};
        default: bus_rdata = '0;
      endcase
  end

  assign irq        = out_rdy & ien_q;
  assign dma_req    = in_rdy & den_q;
  assign core_start = start_q;
  assign core_algo  = algo_q;
  assign core_init  = init_pend;
  assign core_close = close_q && rem <= LEN_W'(64);
  assign core_len   = blk;
  assign core_total = cnt + 32'(blk);

  for (genvar j = 0; j < NWIN; j++) begin : g_blk
    assign core_block[32*j +: 32] = win[j];
  end
  for (genvar i = 0; i < NDIG; i++) begin : g_ctx
    assign core_ctx[32*i +: 32] = dig[i];
  end

  a_r4_start_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    core_start |=> !core_start);
  a_r3_start_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    core_start |-> $past(bus_we));
  a_r8_ordy_from_done: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_rdy) |-> $past(core_done));
  a_r6_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (fin && !clr) |=> cnt == $past(cnt) + 32'($past(blk)));
  a_r12_rem_step: assert property (@(posedge clk) disable iff (!rst_n)
    (fin && !clr) |=> rem == $past(rem) - LEN_W'($past(blk)));
  a_r11_no_start_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
    resetting |-> !core_start);
endmodule

// File: tb/hash_reg_front_tb.sv
module hash_reg_front_tb_top;
  localparam int CLK_NS = 10;
  localparam int LAT    = 5;
  localparam int RSTC   = 4;
  localparam logic [7:0] A_CNT = 8'h14, A_CTRL = 8'h18, A_WIN = 8'h1C,
                         A_REV = 8'h5C, A_MASK = 8'h60, A_SYS = 8'h64;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_we = 1'b0;
  logic [7:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic irq, dma_req, core_start, core_algo, core_init, core_close;
  logic [6:0] core_len;
  logic [31:0] core_total;
  logic [511:0] core_block;
  logic [159:0] core_ctx;
  logic core_done = 1'b0;
  logic [159:0] core_result = '0;

  int n_chk = 0, n_fail = 0;
  logic [31:0] exp_dig [5];
  logic [31:0] exp_cnt;
  bit exp_den = 1'b0;

  always #(CLK_NS/2) clk = ~clk;

  hash_reg_front #(.RST_CYCLES(RSTC)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .dma_req(dma_req),
    .core_start(core_start), .core_algo(core_algo), .core_init(core_init),
    .core_close(core_close), .core_len(core_len), .core_total(core_total),
    .core_block(core_block), .core_ctx(core_ctx), .core_done(core_done),
    .core_result(core_result));

  function automatic logic [31:0] iv(int i);
    return 32'h6745_2301 + 32'(i) * 32'h1111_1111;
  endfunction

  function automatic logic [31:0] word_of(int seed, int k);
    return (32'(seed) + 32'd1) * 32'h9E37_79B9 ^ (32'(k) * 32'h0100_0193);
  endfunction

  // stand-in compression core with fixed latency
  int st_cnt = 0;
  logic [159:0] st_res;
  always @(negedge clk) begin
    core_done = 1'b0;
    if (core_start) begin
      logic [31:0] s;
      s = '0;
      for (int j = 0; j < 16; j++) s = s + core_block[32*j +: 32];
      for (int i = 0; i < 5; i++)
        st_res[32*i +: 32] = (core_init ? iv(i) : core_ctx[32*i +: 32]) + s + core_total
                             + {30'd0, core_close, core_algo} + 32'(i);
      st_cnt = LAT;
    end else if (st_cnt > 0) begin
      st_cnt = st_cnt - 1;
      if (st_cnt == 0) begin
        core_done   = 1'b1;
        core_result = st_res;
      end
    end
  end

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic bw(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic br(logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic rchk(logic [7:0] a, logic [31:0] expv, string tag);
    logic [31:0] d;
    br(a, d);
    chk(d === expv, tag, d, expv);
  endtask

  task automatic do_msg(bit algo, bit init, bit close, int len, int seed, bit poke);
    int rem, blkno;
    bit first;
    logic [31:0] res [5];
    bw(A_CTRL, {27'(len), close, init, algo, 1'b0, 1'b1});
    rem = len; blkno = 0; first = 1'b1;
    while (rem > 0) begin
      int blk, nw;
      logic [31:0] sum, d;
      blk = rem >= 64 ? 64 : rem;
      nw = (blk + 3) / 4;
      sum = '0;
      for (int i = 0; i < nw; i++) begin
        chk(dma_req === exp_den, "R9 dma_req while filling", 32'(dma_req), 32'(exp_den));
        d = word_of(seed, blkno * 16 + i);
        sum = sum + d;
        bw(A_WIN + 8'(4 * i), d);
        if (i < nw - 1)
          chk(core_start === 1'b0, "R4 no early start", 32'(core_start), 0);
        else
          chk(core_start === 1'b1, "R4 start after last word", 32'(core_start), 1);
      end
      chk(dma_req === 1'b0, "R9 dma_req drops", 32'(dma_req), 0);
      chk(core_len === 7'(blk), "R4 core_len", 32'(core_len), 32'(blk));
      chk(core_init === (init && first), "R5 core_init", 32'(core_init), 32'(init && first));
      chk(core_close === (close && rem <= 64), "R5 core_close", 32'(core_close),
          32'(close && rem <= 64));
      chk(core_total === exp_cnt + 32'(blk), "R6 core_total", core_total, exp_cnt + 32'(blk));
      for (int i = 0; i < 5; i++)
        res[i] = ((init && first) ? iv(i) : exp_dig[i]) + sum + exp_cnt + 32'(blk)
                 + {30'd0, (close && rem <= 64), algo} + 32'(i);
      if (poke) begin
        bw(A_WIN + 8'd60, 32'hDEAD_BEEF);
        chk(core_block[511:480] === 32'd0, "R3 window write while busy dropped",
            core_block[511:480], 0);
        rchk(A_CTRL, {27'(len), close, init, algo, 1'b0, 1'b0}, "R3 input-ready low while busy");
        repeat (LAT - 1) @(negedge clk);
      end else begin
        @(negedge clk);
        chk(core_start === 1'b0, "R4 start is one cycle", 32'(core_start), 0);
        repeat (LAT + 1) @(negedge clk);
      end
      for (int i = 0; i < 5; i++) exp_dig[i] = res[i];
      exp_cnt = exp_cnt + 32'(blk);
      rem = rem - blk; blkno++; first = 1'b0;
      if (rem > 0) rchk(A_CTRL, {27'(len), close, init, algo, 1'b1, 1'b1}, "R12 next block ready");
    end
    rchk(A_CTRL, {27'(len), close, init, algo, 1'b0, 1'b1}, "R8 output-ready set, R12 length used up");
    for (int i = 0; i < 5; i++)
      rchk(8'(4 * i), (i == 4 && !algo) ? 32'd0 : exp_dig[i], "R7 digest captured");
    rchk(A_CNT, exp_cnt, "R6 count grows by block bytes");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] d;
    for (int i = 0; i < 5; i++) exp_dig[i] = '0;
    exp_cnt = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    rchk(A_CTRL, 0, "R1 ctrl reset");
    rchk(A_CNT, 0, "R1 count reset");
    for (int i = 0; i < 5; i++) rchk(8'(4 * i), 0, "R1 digest reset");
    rchk(A_MASK, 0, "R1 mask reset");
    rchk(A_SYS, 1, "R1 reset-done");
    chk({irq, dma_req, core_start} === 3'b000, "R1 outputs idle", 32'({irq, dma_req, core_start}), 0);
    rchk(A_REV, 32'h21, "R2 revision fields");
    rchk(8'h68, 0, "R2 unmapped reads zero");
    rchk(8'h02, 0, "R2 unaligned reads zero");
    rchk(A_WIN + 8'd8, 0, "R2 window reads zero");

    bw(A_WIN, 32'h1234_5678);
    chk(core_start === 1'b0, "R3 no start without length", 32'(core_start), 0);
    rchk(A_CTRL, 0, "R3 input-ready low with zero length");

    do_msg(1'b1, 1'b1, 1'b1, 4, 7, 1'b1);

    for (int a = 0; a < 2; a++)
      for (int l = 1; l <= 64; l++)
        do_msg(a[0], 1'b1, 1'b1, l, l + 100 * a, 1'b0);

    do_msg(1'b1, 1'b1, 1'b1, 130, 3, 1'b0);
    do_msg(1'b0, 1'b1, 1'b0, 64, 4, 1'b0);

    for (int i = 0; i < 5; i++) begin
      exp_dig[i] = 32'hA5A5_0000 + 32'(i);
      bw(8'(4 * i), exp_dig[i]);
    end
    exp_cnt = 32'd1000;
    bw(A_CNT, exp_cnt);
    rchk(A_CNT, 32'd1000, "R6 count writable");
    do_msg(1'b0, 1'b0, 1'b1, 10, 5, 1'b0);
    do_msg(1'b1, 1'b0, 1'b1, 70, 6, 1'b0);

    bw(A_MASK, 32'hC);
    rchk(A_MASK, 32'hC, "R9 mask readback");
    exp_den = 1'b1;
    do_msg(1'b1, 1'b1, 1'b1, 64, 8, 1'b0);
    chk(irq === 1'b1, "R8 irq when enabled", 32'(irq), 1);
    bw(A_CTRL, 32'h0);
    rchk(A_CTRL, 32'h1, "R8 write 0 keeps output-ready");
    chk(irq === 1'b1, "R8 irq held", 32'(irq), 1);
    bw(A_CTRL, 32'h1);
    chk(irq === 1'b0, "R8 irq cleared by ack", 32'(irq), 0);

    bw(A_CTRL, {27'd130, 5'b01100});
    chk(dma_req === 1'b1, "R9 dma_req with length", 32'(dma_req), 1);
    bw(A_CTRL, {27'd0, 5'b01100});
    rchk(A_CTRL, 32'h0C, "R10 zero length ends transfer");
    chk(dma_req === 1'b0, "R10 dma_req low", 32'(dma_req), 0);

    bw(A_CTRL, {27'd4, 5'b10101});
    bw(A_MASK, 32'h6);
    rchk(A_SYS, 0, "R11 reset in progress");
    rchk(A_MASK, 32'h2, "R11 soft-reset bit reads 1");
    bw(A_CNT, 32'h55);
    repeat (RSTC) @(negedge clk);
    rchk(A_SYS, 1, "R11 reset done");
    rchk(A_MASK, 0, "R11 mask cleared");
    rchk(A_CNT, 0, "R11 count cleared, write ignored");
    rchk(A_CTRL, 0, "R11 ctrl cleared");
    rchk(8'h00, 0, "R11 digest cleared");
    chk(irq === 1'b0, "R11 irq low", 32'(irq), 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule